// File: doc/BRIEF.md
# Time-Multiplexed Neural Layer Engine

This block evaluates one fully connected neural network layer with a single shared multiply-accumulate datapath. A host first writes the layer's input samples into a small buffer through a load port, then pulses a start strobe. A sequencer visits every neuron in turn and, within each neuron, every input. Each cycle it fetches one sample and its weight and feeds one product into the accumulator. When a neuron's last product is added, the sum is scaled and saturated, then mapped through an activation table. The result leaves on a result port with a one-cycle valid strobe and the neuron's index.

The weights are fixed when the block is built, because training happens elsewhere. Every neuron is wired to every input. A weight of zero removes a connection. Once all neurons have produced a result, a done flag rises and stays high until the next accepted start.

Top module: `nle_layer_engine`

## Requirements
- R1: While reset is asserted and after it is released, with no start given, `res_valid` and `done` are 0.
- R2: A cycle with `load_en` high and no run active writes the signed sample `load_data` into input slot `load_addr`. Loads during a run (start accepted, last result not yet out) are ignored, and the stored samples stay as they were for later runs.
- R3: The weight from input i into neuron n is a 12-bit signed value. It is 0 when (n + 2*i) mod 7 equals 3. Otherwise it is raw = (1237*n + 389*i + 71) mod 4096, read as two's complement (raw - 4096 when raw >= 2048).
- R4: Each neuron's pre-activation sum is the exact signed sum over all 8 inputs of sample times weight. The accumulator starts from zero for every neuron and every run.
- R5: The activation input a is the sum arithmetically shifted right by 12 bits and saturated to [-128, 127]. The output is a when a >= 0 and floor(a/4) (arithmetic shift by 2) when a < 0, given as an 8-bit two's complement value.
- R6: One run gives exactly 7 results, for neuron indices 0 to 6 in rising order, each with a single-cycle `res_valid`. The result of neuron n appears 8n + 10 rising edges after the edge that samples `start`.
- R7: `done` goes to 1 in the cycle after the strobe of neuron 6 and holds there. It goes back to 0 on the edge that accepts the next start.
- R8: A start pulse during a run is ignored. The result order and timing of the current run are unchanged.
- R9: Full-scale inputs (all -128 or all 127) give results without accumulator wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Write one input sample |
| load_addr | input | 3 | Input slot to write |
| load_data | input | 8 | Signed input sample |
| start | input | 1 | Begin evaluating the layer |
| res_valid | output | 1 | One-cycle strobe for a finished neuron |
| res_idx | output | 3 | Index of the neuron whose result is present |
| res_data | output | 8 | Signed activated result |
| done | output | 1 | All neurons finished; held until the next start |

## Verification
The assertions assume that the host pulses start only after reset has been released through the internal synchronizer, and that it addresses only existing input slots. Under those conditions, done never coincides with a result strobe, and sums are strobed for a single cycle. The bench writes every slot before each fresh run and keeps load addresses inside 0 to 7. It drives conflicting start and load pulses only in the middle of a run, where the requirements say they must be ignored. Random samples come from a fixed seed. The directed runs add one-hot 127 patterns, which show each weight, and full-scale patterns, which drive the saturation edges.

// File: rtl/nle_pkg.sv
package nle_pkg;
  localparam int unsigned DEF_NEURONS  = 7;
  localparam int unsigned DEF_INPUTS   = 8;
  localparam int unsigned DEF_DATA_W   = 8;
  localparam int unsigned DEF_WEIGHT_W = 12;
  localparam int unsigned DEF_OUT_W    = 8;
  localparam int unsigned DEF_SHIFT    = 12;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_e;

  function automatic int unsigned idx_width(int unsigned count);
    return (count < 2) ? 1 : $clog2(count);
  endfunction
endpackage

// File: rtl/nle_seq.sv
module nle_seq
  import nle_pkg::*;
#(
  parameter int unsigned N_NEURONS = DEF_NEURONS,
  parameter int unsigned N_INPUTS  = DEF_INPUTS,
  parameter int unsigned NIDX_W    = idx_width(N_NEURONS),
  parameter int unsigned IIDX_W    = idx_width(N_INPUTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fin_v,
  input  logic [NIDX_W-1:0] fin_idx,
  output logic              rd_en,
  output logic [NIDX_W-1:0] rd_n,
  output logic [IIDX_W-1:0] rd_i,
  output logic              rd_first,
  output logic              rd_last,
  output logic              run_active,
  output logic              done
);
  localparam logic [NIDX_W-1:0] LAST_N = NIDX_W'(N_NEURONS - 1);
  localparam logic [IIDX_W-1:0] LAST_I = IIDX_W'(N_INPUTS - 1);

  seq_state_e        state_q, state_d;
  logic [NIDX_W-1:0] n_q, n_d;
  logic [IIDX_W-1:0] i_q, i_d;
  logic              done_q, done_d;
  logic              cnt_en;
  logic              last_i, last_n;

  assign last_i = (i_q == LAST_I);
  assign last_n = (n_q == LAST_N);
  assign cnt_en = (state_q == SEQ_ISSUE) || ((state_q == SEQ_IDLE) && start);

  always_comb begin
    state_d = state_q;
    n_d     = n_q;
    i_d     = i_q;
    done_d  = done_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_ISSUE;
          n_d     = '0;
          i_d     = '0;
          done_d  = 1'b0;
        end
      end
      SEQ_ISSUE: begin
        if (last_i) begin
          i_d = '0;
          if (last_n) begin
            state_d = SEQ_DRAIN;
          end else begin
            n_d = n_q + NIDX_W'(1);
          end
        end else begin
          i_d = i_q + IIDX_W'(1);
        end
      end
      SEQ_DRAIN: begin
        if (fin_v && (fin_idx == LAST_N)) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_q <= '0;
      i_q <= '0;
    end else if (cnt_en) begin
      n_q <= n_d;
      i_q <= i_d;
    end
  end

  assign rd_en      = (state_q == SEQ_ISSUE);
  assign rd_n       = n_q;
  assign rd_i       = i_q;
  assign rd_first   = (i_q == '0);
  assign rd_last    = last_i;
  assign run_active = (state_q != SEQ_IDLE);
  assign done       = done_q;

  // R7
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(fin_v) && ($past(fin_idx) == LAST_N)));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_active && start && !(fin_v && (fin_idx == LAST_N))) |=> run_active);

  // R6
  issue_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((32'(n_q) < N_NEURONS) && (32'(i_q) < N_INPUTS)));
endmodule

// File: rtl/nle_mem.sv
module nle_mem
  import nle_pkg::*;
#(
  parameter int unsigned N_NEURONS = DEF_NEURONS,
  parameter int unsigned N_INPUTS  = DEF_INPUTS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned WEIGHT_W  = DEF_WEIGHT_W,
  parameter int unsigned NIDX_W    = idx_width(N_NEURONS),
  parameter int unsigned IIDX_W    = idx_width(N_INPUTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IIDX_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [NIDX_W-1:0]   rd_n,
  input  logic [IIDX_W-1:0]   rd_i,
  input  logic                rd_first,
  input  logic                rd_last,
  output logic [DATA_W-1:0]   x_q,
  output logic [WEIGHT_W-1:0] w_q,
  output logic                tag_v,
  output logic                tag_first,
  output logic                tag_last,
  output logic [NIDX_W-1:0]   tag_n
);
  localparam logic [IIDX_W:0] IN_CNT = (IIDX_W + 1)'(N_INPUTS);
  localparam int unsigned     W_MOD  = 1 << WEIGHT_W;

  logic [DATA_W-1:0] samples_q [N_INPUTS];
  logic              wr_ok;

  // weight table computed from the pair indices; a zero entry cuts the link
  function automatic logic [WEIGHT_W-1:0] coef(int unsigned n, int unsigned i);
    int unsigned mix;
    mix = (n * 1237 + i * 389 + 71) % W_MOD;
    if (((n + 2 * i) % 7) == 3) begin
      return '0;
    end
    return mix[WEIGHT_W-1:0];
  endfunction

  assign wr_ok = wr_en && ({1'b0, wr_addr} < IN_CNT);

  always_ff @(posedge clk) begin
    if (wr_ok) begin
      samples_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      x_q <= samples_q[rd_i];
      w_q <= coef(32'(rd_n), 32'(rd_i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_v     <= 1'b0;
      tag_first <= 1'b0;
      tag_last  <= 1'b0;
      tag_n     <= '0;
    end else begin
      tag_v <= rd_en;
      if (rd_en) begin
        tag_first <= rd_first;
        tag_last  <= rd_last;
        tag_n     <= rd_n;
      end
    end
  end
endmodule

// File: rtl/nle_mac.sv
module nle_mac
  import nle_pkg::*;
#(
  parameter int unsigned N_INPUTS = DEF_INPUTS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned WEIGHT_W = DEF_WEIGHT_W,
  parameter int unsigned ACC_W    = DATA_W + WEIGHT_W + idx_width(N_INPUTS),
  parameter int unsigned NIDX_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_v,
  input  logic                    in_first,
  input  logic                    in_last,
  input  logic [NIDX_W-1:0]       in_n,
  input  logic signed [DATA_W-1:0]   x,
  input  logic signed [WEIGHT_W-1:0] w,
  output logic                    sum_v,
  output logic signed [ACC_W-1:0] sum,
  output logic [NIDX_W-1:0]       sum_idx
);
  localparam int unsigned PROD_W = DATA_W + WEIGHT_W;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q, acc_d, acc_base;
  logic                     sum_v_q;
  logic [NIDX_W-1:0]        idx_q;

  assign prod     = x * w;
  assign prod_ext = ACC_W'(prod);
  assign acc_base = in_first ? {ACC_W{1'b0}} : acc_q;
  assign acc_d    = acc_base + prod_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (in_v) begin
      acc_q <= acc_d;
      idx_q <= in_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_v_q <= 1'b0;
    end else begin
      sum_v_q <= in_v && in_last;
    end
  end

  assign sum_v   = sum_v_q;
  assign sum     = acc_q;
  assign sum_idx = idx_q;

  generate
    if (N_INPUTS > 1) begin : g_pulse
      // R6
      sum_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sum_v_q |=> !sum_v_q);
    end
  endgenerate
endmodule

// File: rtl/nle_act.sv
module nle_act
  import nle_pkg::*;
#(
  parameter int unsigned ACC_W  = 23,
  parameter int unsigned OUT_W  = DEF_OUT_W,
  parameter int unsigned SHIFT  = DEF_SHIFT,
  parameter int unsigned NIDX_W = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sum_v,
  input  logic signed [ACC_W-1:0] sum,
  input  logic [NIDX_W-1:0]       sum_idx,
  output logic                    res_v,
  output logic [NIDX_W-1:0]       res_idx,
  output logic [OUT_W-1:0]        res_data
);
  localparam logic signed [ACC_W-1:0] HI_ACC = ACC_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] LO_ACC = ~HI_ACC;
  localparam logic signed [OUT_W-1:0] HI_OUT = OUT_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [OUT_W-1:0] LO_OUT = ~HI_OUT;
  localparam logic signed [OUT_W-1:0] FLOOR  = LO_OUT >>> 2;

  logic signed [ACC_W-1:0] scaled;
  logic signed [OUT_W-1:0] addr;
  logic signed [OUT_W-1:0] entry;
  logic signed [OUT_W-1:0] res_q;
  logic                    res_v_q;
  logic [NIDX_W-1:0]       idx_q;

  // table entry: identity for the positive half, quarter slope below zero
  function automatic logic signed [OUT_W-1:0] table_at(logic signed [OUT_W-1:0] a);
    return a[OUT_W-1] ? (a >>> 2) : a;
  endfunction

  assign scaled = sum >>> SHIFT;

  always_comb begin
    if (scaled > HI_ACC) begin
      addr = HI_OUT;
    end else if (scaled < LO_ACC) begin
      addr = LO_OUT;
    end else begin
      addr = scaled[OUT_W-1:0];
    end
  end

  assign entry = table_at(addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_v_q <= 1'b0;
    end else begin
      res_v_q <= sum_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      idx_q <= '0;
    end else if (sum_v) begin
      res_q <= entry;
      idx_q <= sum_idx;
    end
  end

  assign res_v    = res_v_q;
  assign res_idx  = idx_q;
  assign res_data = res_q;

  // R5
  act_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_v_q |-> (res_q >= FLOOR));
endmodule

// File: rtl/nle_layer_engine.sv
module nle_layer_engine
  import nle_pkg::*;
#(
  parameter int unsigned N_NEURONS = DEF_NEURONS,
  parameter int unsigned N_INPUTS  = DEF_INPUTS,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned WEIGHT_W  = DEF_WEIGHT_W,
  parameter int unsigned OUT_W     = DEF_OUT_W,
  parameter int unsigned ACC_SHIFT = DEF_SHIFT,
  localparam int unsigned NIDX_W   = idx_width(N_NEURONS),
  localparam int unsigned IIDX_W   = idx_width(N_INPUTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [IIDX_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  input  logic              start,
  output logic              res_valid,
  output logic [NIDX_W-1:0] res_idx,
  output logic [OUT_W-1:0]  res_data,
  output logic              done
);
  localparam int unsigned ACC_W = DATA_W + WEIGHT_W + idx_width(N_INPUTS);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic              rd_en, rd_first, rd_last, run_active;
  logic [NIDX_W-1:0] rd_n;
  logic [IIDX_W-1:0] rd_i;
  logic [DATA_W-1:0] x_q;
  logic [WEIGHT_W-1:0] w_q;
  logic              tag_v, tag_first, tag_last;
  logic [NIDX_W-1:0] tag_n;
  logic              sum_v;
  logic signed [ACC_W-1:0] sum;
  logic [NIDX_W-1:0] sum_idx;
  logic              fin_v;
  logic [NIDX_W-1:0] fin_idx;
  logic              load_ok;

  assign load_ok = load_en && !run_active;

  nle_seq #(
    .N_NEURONS(N_NEURONS), .N_INPUTS(N_INPUTS), .NIDX_W(NIDX_W), .IIDX_W(IIDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(start), .fin_v(fin_v), .fin_idx(fin_idx),
    .rd_en(rd_en), .rd_n(rd_n), .rd_i(rd_i), .rd_first(rd_first), .rd_last(rd_last),
    .run_active(run_active), .done(done)
  );

  nle_mem #(
    .N_NEURONS(N_NEURONS), .N_INPUTS(N_INPUTS), .DATA_W(DATA_W), .WEIGHT_W(WEIGHT_W),
    .NIDX_W(NIDX_W), .IIDX_W(IIDX_W)
  ) u_mem (
    .clk(clk), .rst_n(rst_int_n), .wr_en(load_ok), .wr_addr(load_addr), .wr_data(load_data),
    .rd_en(rd_en), .rd_n(rd_n), .rd_i(rd_i), .rd_first(rd_first), .rd_last(rd_last),
    .x_q(x_q), .w_q(w_q), .tag_v(tag_v), .tag_first(tag_first), .tag_last(tag_last),
    .tag_n(tag_n)
  );

  nle_mac #(
    .N_INPUTS(N_INPUTS), .DATA_W(DATA_W), .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W), .NIDX_W(NIDX_W)
  ) u_mac (
    .clk(clk), .rst_n(rst_int_n), .in_v(tag_v), .in_first(tag_first), .in_last(tag_last),
    .in_n(tag_n), .x(x_q), .w(w_q), .sum_v(sum_v), .sum(sum), .sum_idx(sum_idx)
  );

  nle_act #(
    .ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(ACC_SHIFT), .NIDX_W(NIDX_W)
  ) u_act (
    .clk(clk), .rst_n(rst_int_n), .sum_v(sum_v), .sum(sum), .sum_idx(sum_idx),
    .res_v(fin_v), .res_idx(fin_idx), .res_data(res_data)
  );

  assign res_valid = fin_v;
  assign res_idx   = fin_idx;

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !res_valid);
endmodule

// File: tb/tb_nle_layer_engine.sv
module tb_nle_layer_engine;
  localparam int NN = 7;
  localparam int NI = 8;

  logic       clk;
  logic       rst_n;
  logic       load_en;
  logic [2:0] load_addr;
  logic [7:0] load_data;
  logic       start;
  logic       res_valid;
  logic [2:0] res_idx;
  logic [7:0] res_data;
  logic       done;

  int checks = 0;
  int errors = 0;
  int xin [NI];

  nle_layer_engine dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .start(start), .res_valid(res_valid), .res_idx(res_idx),
    .res_data(res_data), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int w_exp(int n, int i);
    int raw;
    if (((n + 2 * i) % 7) == 3) return 0;
    raw = (1237 * n + 389 * i + 71) % 4096;
    return (raw >= 2048) ? raw - 4096 : raw;
  endfunction

  function automatic int sum_exp(int n);
    int s = 0;
    for (int i = 0; i < NI; i++) s += xin[i] * w_exp(n, i);
    return s;
  endfunction

  function automatic int act_exp(int s);
    int a = s >>> 12;
    if (a > 127) a = 127;
    if (a < -128) a = -128;
    return (a >= 0) ? a : (a >>> 2);
  endfunction

  function automatic bit saturates(int s);
    int a = s >>> 12;
    return (a > 127) || (a < -128);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < NI; i++) begin
      @(negedge clk);
      load_en   = 1'b1;
      load_addr = 3'(i);
      load_data = 8'(xin[i]);
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // tag names the requirement for the data checks; inject disturbs the run
  task automatic run(string tag, bit inject);
    int got = 0;
    string treq;
    treq = inject ? "R8" : "R6";
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done == 1'b0, "R7", int'(done), 0);
    for (int c = 1; c <= 62; c++) begin
      if (res_valid) begin
        int e = act_exp(sum_exp(got));
        string dreq;
        dreq = (tag != "") ? tag : (saturates(sum_exp(got)) ? "R5" : "R4");
        check(int'(res_idx) == got, treq, int'(res_idx), got);
        check(c == 8 * got + 11, treq, c, 8 * got + 11);
        check(int'($signed(res_data)) == e, dreq, int'($signed(res_data)), e);
        got++;
      end
      if (c == 30) check(done == 1'b0, "R7", int'(done), 0);
      if (c == 60 || c == 62) begin
        check(done == 1'b1, "R7", int'(done), 1);
        check(res_valid == 1'b0, "R7", int'(res_valid), 0);
      end
      if (inject && c == 20) begin
        start     = 1'b1;
        load_en   = 1'b1;
        load_addr = 3'd0;
        load_data = ~8'(xin[0]);
      end
      if (inject && c == 21) begin
        start   = 1'b0;
        load_en = 1'b0;
      end
      @(negedge clk);
    end
    check(got == NN, treq, got, NN);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL R6: watchdog expired, got %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start = 1'b0;
    load_en = 1'b0;
    load_addr = '0;
    load_data = '0;
    repeat (3) @(negedge clk);
    check(res_valid == 1'b0, "R1", int'(res_valid), 0);
    check(done == 1'b0, "R1", int'(done), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(res_valid == 1'b0, "R1", int'(res_valid), 0);
    check(done == 1'b0, "R1", int'(done), 0);

    // one-hot 127 patterns expose each weight column, zeros included
    for (int j = 0; j < NI; j++) begin
      for (int i = 0; i < NI; i++) xin[i] = (i == j) ? 127 : 0;
      load_all();
      run("R3", 1'b0);
    end

    // full-scale extremes
    for (int i = 0; i < NI; i++) xin[i] = -128;
    load_all();
    run("R9", 1'b0);
    for (int i = 0; i < NI; i++) xin[i] = 127;
    load_all();
    run("R9", 1'b0);

    // small values stay in the linear range of the table
    for (int i = 0; i < NI; i++) xin[i] = (i % 2 == 0) ? 3 : -5;
    load_all();
    run("", 1'b0);

    // random runs
    for (int r = 0; r < 8; r++) begin
      for (int i = 0; i < NI; i++) xin[i] = int'($urandom_range(255)) - 128;
      load_all();
      run("", 1'b0);
    end

    // start and load during a run are ignored; rerun without reload
    for (int i = 0; i < NI; i++) xin[i] = int'($urandom_range(255)) - 128;
    load_all();
    run("", 1'b1);
    run("R2", 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule